// File: doc/BRIEF.md
# Shared Wishbone Bus Arbiter

This block lets a configurable number of Wishbone masters share a single pipelined slave port. Each master presents cycle, strobe, write-enable, byte-select, address and write data. The arbiter forwards the request fields of exactly one selected master to the slave. It routes the slave's ack and stall back to that master alone, and places the slave's read data on every master's data output.

Ownership is held in a register and needs no idle slot. A small two-state machine tracks whether the bus is locked. In ARB_PARKED, the last owner is remembered but its cycle signal was low at the last edge. In ARB_BUSY, the owner held its cycle signal at the last edge.

The transitions are:

- claim (ARB_PARKED to ARB_BUSY): a request appears on a free bus.
- rest (ARB_PARKED to ARB_PARKED): nobody requests.
- hold (ARB_BUSY to ARB_BUSY): the owner keeps its cycle high.
- handover (ARB_BUSY to ARB_BUSY with a new owner): the owner drops its cycle while another master requests.
- release (ARB_BUSY to ARB_PARKED): the owner drops its cycle and nobody else requests.

On claim and handover the selection moves combinationally in the same cycle the request is seen, so no latency cycle is added. When several masters request a free bus, the lowest index wins.

Top module: `bus_share_arb`

## Requirements
- R1: After reset, master 0 is the parked owner. With no request, s_cyc is 0, m_stall[0] equals s_stall, and every other m_stall bit is 1.
- R2: While the owner keeps its cycle bit high, it stays selected, even if a lower-indexed master raises its cycle bit.
- R3: When the bus is free (the owner's cycle bit is low), a requesting master is forwarded to the slave in the same cycle its cycle bit first rises.
- R4: When several masters request a free bus, the one with the lowest index is selected.
- R5: Every master that is not selected sees its stall bit at 1, whatever s_stall is.
- R6: The selected master's stall bit equals s_stall.
- R7: Only the selected master's ack bit can be 1, and it equals s_ack. All other ack bits are 0.
- R8: s_cyc, s_stb, s_we, s_sel, s_adr and s_dat_w are the selected master's fields, taken from slice i of each packed master bus (master i occupies bits i*W to i*W+W-1). s_cyc is 0 when no master requests.
- R9: With no request pending, the last owner stays selected. It can start a new cycle, after a gap or back to back, without any extra latency cycle.
- R10: Every master's read-data slice equals s_dat_r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | N_MST | Cycle request, one bit per master |
| m_stb | input | N_MST | Strobe, one bit per master |
| m_we | input | N_MST | Write enable, one bit per master |
| m_sel | input | N_MST*SEL_W | Byte selects, packed per master |
| m_adr | input | N_MST*ADDR_W | Addresses, packed per master |
| m_dat_w | input | N_MST*DATA_W | Write data, packed per master |
| m_dat_r | output | N_MST*DATA_W | Read data to each master |
| m_ack | output | N_MST | Ack to each master |
| m_stall | output | N_MST | Stall to each master |
| s_cyc | output | 1 | Cycle to slave |
| s_stb | output | 1 | Strobe to slave |
| s_we | output | 1 | Write enable to slave |
| s_sel | output | SEL_W | Byte selects to slave |
| s_adr | output | ADDR_W | Address to slave |
| s_dat_w | output | DATA_W | Write data to slave |
| s_dat_r | input | DATA_W | Read data from slave |
| s_ack | input | 1 | Ack from slave |
| s_stall | input | 1 | Stall from slave |

## Verification
The following properties are checked on every cycle:

- At most one master sees stall low, and at most one sees ack.
- Any ack implies a slave ack.
- The slave cycle signal is low when nobody requests.
- A live owner is never displaced.
- The selection stays put when the bus is empty.
- On a free bus, the lowest requester wins at once.

Only the bench scenarios show that the correct fields reach the slave. They also show the exact order of claim, hold, handover and release across a sequence, and the data broadcast and stall values for a parked owner.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        ARB_PARKED = 1'b0,
        ARB_BUSY   = 1'b1
    } arb_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bsa_prio_pick.sv
module bsa_prio_pick #(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_REQ-1:0] req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/bsa_req_mux.sv
module bsa_req_mux #(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic [N_REQ-1:0]        gnt_oh,
    input  logic [N_REQ-1:0]        m_cyc,
    input  logic [N_REQ-1:0]        m_stb,
    input  logic [N_REQ-1:0]        m_we,
    input  logic [N_REQ*SEL_W-1:0]  m_sel,
    input  logic [N_REQ*ADDR_W-1:0] m_adr,
    input  logic [N_REQ*DATA_W-1:0] m_dat_w,
    output logic                    s_cyc,
    output logic                    s_stb,
    output logic                    s_we,
    output logic [SEL_W-1:0]        s_sel,
    output logic [ADDR_W-1:0]       s_adr,
    output logic [DATA_W-1:0]       s_dat_w
);

    // One-hot AND-OR selection: a single level of gating per bit.
    always_comb begin
        s_cyc   = 1'b0;
        s_stb   = 1'b0;
        s_we    = 1'b0;
        s_sel   = '0;
        s_adr   = '0;
        s_dat_w = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt_oh[i]) begin
                s_cyc   = s_cyc   | m_cyc[i];
                s_stb   = s_stb   | m_stb[i];
                s_we    = s_we    | m_we[i];
                s_sel   = s_sel   | m_sel[i*SEL_W +: SEL_W];
                s_adr   = s_adr   | m_adr[i*ADDR_W +: ADDR_W];
                s_dat_w = s_dat_w | m_dat_w[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/bsa_rsp_route.sv
module bsa_rsp_route #(
    parameter int N_REQ  = 4,
    parameter int DATA_W = 32
) (
    input  logic [N_REQ-1:0]        gnt_oh,
    input  logic                    s_ack,
    input  logic                    s_stall,
    input  logic [DATA_W-1:0]       s_dat_r,
    output logic [N_REQ-1:0]        m_ack,
    output logic [N_REQ-1:0]        m_stall,
    output logic [N_REQ*DATA_W-1:0] m_dat_r
);

    for (genvar g = 0; g < N_REQ; g++) begin : g_port
        assign m_ack[g]                   = gnt_oh[g] & s_ack;
        assign m_stall[g]                 = gnt_oh[g] ? s_stall : 1'b1;
        assign m_dat_r[g*DATA_W +: DATA_W] = s_dat_r;
    end

endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb
    import bsa_pkg::*;
#(
    parameter  int N_MST  = 4,
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int SEL_W  = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_MST-1:0]        m_cyc,
    input  logic [N_MST-1:0]        m_stb,
    input  logic [N_MST-1:0]        m_we,
    input  logic [N_MST*SEL_W-1:0]  m_sel,
    input  logic [N_MST*ADDR_W-1:0] m_adr,
    input  logic [N_MST*DATA_W-1:0] m_dat_w,
    output logic [N_MST*DATA_W-1:0] m_dat_r,
    output logic [N_MST-1:0]        m_ack,
    output logic [N_MST-1:0]        m_stall,
    output logic                    s_cyc,
    output logic                    s_stb,
    output logic                    s_we,
    output logic [SEL_W-1:0]        s_sel,
    output logic [ADDR_W-1:0]       s_adr,
    output logic [DATA_W-1:0]       s_dat_w,
    input  logic [DATA_W-1:0]       s_dat_r,
    input  logic                    s_ack,
    input  logic                    s_stall
);

    localparam int IDX_W = idx_width(N_MST);

    arb_state_e       state_q;
    arb_state_e       state_d;
    logic [IDX_W-1:0] own_q;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic             owner_live;
    logic [N_MST-1:0] gnt_oh;

    bsa_prio_pick #(
        .N_REQ (N_MST),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (m_cyc),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign owner_live = m_cyc[own_q];

    // Selection and next state: combinational, so a claim or a
    // handover reaches the slave in the cycle the request appears.
    always_comb begin
        sel_idx = own_q;
        state_d = state_q;
        unique case (state_q)
            ARB_BUSY: begin
                if (owner_live) begin
                    sel_idx = own_q;           // hold
                    state_d = ARB_BUSY;
                end else if (pick_any) begin
                    sel_idx = pick_idx;        // handover
                    state_d = ARB_BUSY;
                end else begin
                    sel_idx = own_q;           // release, owner stays parked
                    state_d = ARB_PARKED;
                end
            end
            ARB_PARKED: begin
                if (pick_any) begin
                    sel_idx = pick_idx;        // claim
                    state_d = ARB_BUSY;
                end else begin
                    sel_idx = own_q;           // rest
                    state_d = ARB_PARKED;
                end
            end
        endcase
    end

    // State and owner registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_PARKED;
            own_q   <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= sel_idx;
        end
    end

    for (genvar g = 0; g < N_MST; g++) begin : g_dec
        assign gnt_oh[g] = (sel_idx == IDX_W'(g));
    end

    bsa_req_mux #(
        .N_REQ  (N_MST),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_req_mux (
        .gnt_oh  (gnt_oh),
        .m_cyc   (m_cyc),
        .m_stb   (m_stb),
        .m_we    (m_we),
        .m_sel   (m_sel),
        .m_adr   (m_adr),
        .m_dat_w (m_dat_w),
        .s_cyc   (s_cyc),
        .s_stb   (s_stb),
        .s_we    (s_we),
        .s_sel   (s_sel),
        .s_adr   (s_adr),
        .s_dat_w (s_dat_w)
    );

    bsa_rsp_route #(
        .N_REQ  (N_MST),
        .DATA_W (DATA_W)
    ) u_rsp_route (
        .gnt_oh  (gnt_oh),
        .s_ack   (s_ack),
        .s_stall (s_stall),
        .s_dat_r (s_dat_r),
        .m_ack   (m_ack),
        .m_stall (m_stall),
        .m_dat_r (m_dat_r)
    );

endmodule

// File: rtl/bus_share_arb_chk.sv
module bus_share_arb_chk #(
    parameter int N_MST = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_MST-1:0] m_cyc,
    input logic [N_MST-1:0] m_ack,
    input logic [N_MST-1:0] m_stall,
    input logic             s_cyc,
    input logic             s_ack,
    input logic             s_stall,
    input logic [IDX_W-1:0] sel_idx
);

    logic [IDX_W-1:0] sel_d;
    logic             held_d;
    logic             prev_v;
    logic             lower_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d  <= '0;
            held_d <= 1'b0;
            prev_v <= 1'b0;
        end else begin
            sel_d  <= sel_idx;
            held_d <= m_cyc[sel_idx];
            prev_v <= 1'b1;
        end
    end

    always_comb begin
        lower_req = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (IDX_W'(i) < sel_idx) begin
                lower_req = lower_req | m_cyc[i];
            end
        end
    end

    p_stall_iso_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(~m_stall) <= 1);

    p_stall_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (s_cyc && !s_stall) |-> ($countones(~m_stall) == 1));

    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_ack));

    p_ack_source_r7: assert property (@(posedge clk) disable iff (rst)
        (|m_ack) |-> s_ack);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (m_cyc == '0) |-> !s_cyc);

    p_keep_owner_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_v && held_d && m_cyc[sel_d]) |-> (sel_idx == sel_d));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (prev_v && (m_cyc == '0)) |-> (sel_idx == sel_d));

    p_free_pick_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_v && !m_cyc[sel_d] && (m_cyc != '0)) |-> (m_cyc[sel_idx] && !lower_req));

    p_same_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (prev_v && !m_cyc[sel_d] && (m_cyc != '0)) |-> s_cyc);

endmodule

bind bus_share_arb bus_share_arb_chk #(
    .N_MST (N_MST),
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .m_cyc   (m_cyc),
    .m_ack   (m_ack),
    .m_stall (m_stall),
    .s_cyc   (s_cyc),
    .s_ack   (s_ack),
    .s_stall (s_stall),
    .sel_idx (sel_idx)
);

// File: tb/bus_share_arb_tb.sv
module bus_share_arb_tb;

    localparam int NM = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [NM-1:0]    m_cyc = '0;
    logic [NM-1:0]    m_stb = '0;
    logic [NM-1:0]    m_we  = 3'b101;
    logic [NM*SW-1:0] m_sel = {4'hC, 4'h3, 4'hF};
    logic [NM*AW-1:0] m_adr = {16'h3C00, 16'h2B00, 16'h1A00};
    logic [NM*DW-1:0] m_dat_w = {32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    logic [NM*DW-1:0] m_dat_r;
    logic [NM-1:0]    m_ack;
    logic [NM-1:0]    m_stall;
    logic             s_cyc, s_stb, s_we;
    logic [SW-1:0]    s_sel;
    logic [AW-1:0]    s_adr;
    logic [DW-1:0]    s_dat_w;
    logic [DW-1:0]    s_dat_r = '0;
    logic             s_ack   = 1'b0;
    logic             s_stall = 1'b0;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 1'b0;

    typedef struct {
        int          sel;
        logic [2:0]  cyc;
        logic [2:0]  stb;
        logic        st;
        logic        ak;
        logic [31:0] rd;
        string       rq;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    bus_share_arb #(
        .N_MST  (NM),
        .ADDR_W (AW),
        .DATA_W (DW)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .m_cyc   (m_cyc),
        .m_stb   (m_stb),
        .m_we    (m_we),
        .m_sel   (m_sel),
        .m_adr   (m_adr),
        .m_dat_w (m_dat_w),
        .m_dat_r (m_dat_r),
        .m_ack   (m_ack),
        .m_stall (m_stall),
        .s_cyc   (s_cyc),
        .s_stb   (s_stb),
        .s_we    (s_we),
        .s_sel   (s_sel),
        .s_adr   (s_adr),
        .s_dat_w (s_dat_w),
        .s_dat_r (s_dat_r),
        .s_ack   (s_ack),
        .s_stall (s_stall)
    );

    // Driver: apply one cycle of stimulus and queue the expected selection.
    task automatic step(input logic [2:0] cyc, input logic [2:0] stb,
                        input logic st, input logic ak,
                        input int exp_sel, input string rq);
        item_t it;
        @(posedge clk);
        #1;
        m_cyc   = cyc;
        m_stb   = stb;
        s_stall = st;
        s_ack   = ak;
        s_dat_r = 32'h5000_0000 + 32'(n_vec + exp_q.size());
        it.sel = exp_sel;
        it.cyc = cyc;
        it.stb = stb;
        it.st  = st;
        it.ak  = ak;
        it.rd  = s_dat_r;
        it.rq  = rq;
        exp_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge of the same cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                logic [NM-1:0]    e_ack, e_stall;
                logic [NM*DW-1:0] e_dr;
                logic [1+1+1+SW+AW+DW+NM+NM+NM*DW-1:0] e_v, a_v;
                it = exp_q.pop_front();
                for (int i = 0; i < NM; i++) begin
                    e_ack[i]   = (i == it.sel) ? it.ak : 1'b0;
                    e_stall[i] = (i == it.sel) ? it.st : 1'b1;
                    e_dr[i*DW +: DW] = it.rd;
                end
                e_v = {it.cyc[it.sel], it.stb[it.sel], m_we[it.sel],
                       m_sel[it.sel*SW +: SW], m_adr[it.sel*AW +: AW],
                       m_dat_w[it.sel*DW +: DW], e_ack, e_stall, e_dr};
                a_v = {s_cyc, s_stb, s_we, s_sel, s_adr, s_dat_w,
                       m_ack, m_stall, m_dat_r};
                n_vec++;
                if (a_v !== e_v) begin
                    n_miss++;
                    $display("FAIL %s: actual %h expected %h", it.rq, a_v, e_v);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: parked on master 0 after reset, no request
        step(3'b000, 3'b000, 1'b0, 1'b0, 0, "R1 reset park");
        step(3'b000, 3'b000, 1'b1, 1'b0, 0, "R1 reset park stall");
        // R3: master 2 claims a free bus in the same cycle
        step(3'b100, 3'b100, 1'b0, 1'b0, 2, "R3 claim");
        // R2 / R7: master 0 waits while 2 holds; ack only to 2
        step(3'b101, 3'b101, 1'b0, 1'b1, 2, "R2 R7 hold ack");
        // R5 / R6: slave stall passes to owner, waiters stay stalled
        step(3'b101, 3'b101, 1'b1, 1'b0, 2, "R5 R6 stall");
        // R3: handover to master 0 the cycle 2 drops
        step(3'b001, 3'b001, 1'b0, 1'b0, 0, "R3 handover");
        // R8: strobe low on owner reaches slave as low
        step(3'b001, 3'b000, 1'b0, 1'b1, 0, "R8 R7 stb low");
        // R9: idle, sticky on master 0
        step(3'b000, 3'b000, 1'b0, 1'b0, 0, "R9 sticky");
        // R4: masters 1 and 2 request together, 1 wins
        step(3'b110, 3'b110, 1'b0, 1'b0, 1, "R4 priority");
        // R2: master 0 cannot preempt the live owner 1
        step(3'b111, 3'b111, 1'b0, 1'b1, 1, "R2 no preempt");
        // R4: master 1 drops, 0 beats 2
        step(3'b101, 3'b101, 1'b0, 1'b0, 0, "R4 free pick");
        step(3'b000, 3'b000, 1'b1, 1'b0, 0, "R8 idle quiet");
        step(3'b100, 3'b100, 1'b0, 1'b0, 2, "R3 claim m2");
        // R9: parked on 2, its stall follows slave, others stalled
        step(3'b000, 3'b000, 1'b0, 1'b0, 2, "R9 parked m2");
        step(3'b100, 3'b100, 1'b0, 1'b1, 2, "R9 restart no gap");
        step(3'b100, 3'b100, 1'b0, 1'b1, 2, "R9 back to back");
        // R5: waiting master 1 stays stalled though slave is ready
        step(3'b110, 3'b110, 1'b0, 1'b0, 2, "R5 waiter stalled");
        // R10: read data reaches all masters
        step(3'b010, 3'b010, 1'b0, 1'b1, 1, "R10 R6 broadcast");
        step(3'b000, 3'b000, 1'b0, 1'b0, 1, "R9 parked m1");

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule